// File: doc/BRIEF.md
# Strand Dispatch Engine with Dirty-Register Repair

This block sits in the front end of an out-of-order core, after decode and before rename. Each cycle it takes one pre-renamed instruction and sends its address to a strand lookup port. A strand is a short chain of three dependent ALU instructions whose intermediate results are each read once. When the lookup reports a hit and the strand's live inputs are ready, the engine sends the whole strand downstream in place of the matching instruction. It then records which two later instruction addresses complete the strand. When those instructions arrive, the engine drops them.

Collapsing a chain this way means the two intermediate registers are never written. The engine keeps a dirty table with one bit per architectural register, plus the slot that made the register dirty. If an ordinary instruction reads a dirty register, the engine stalls the input and emits a recovery sub-strand that rebuilds that register. The strand also writes its final register early. If an ordinary instruction reads that register before the strand's last member arrives, the engine emits a load-immediate that restores the value the lookup port supplied at insertion. It then drops its tracking of that strand, so the remaining members run as ordinary instructions. A branch flush clears all tracking, and a kill pulse names every strand slot that was still in flight.

Top module: `strand_dispatch`

## Requirements
- R1: After reset, `outValid` is 0, `killMask` is 0, no slot is active, no register is dirty, and `inReady` is 1.
- R2: An instruction that is not a strand member, reads no dirty register, reads no active strand's final register, and does not start a strand appears one cycle later with `outKind`=0 (plain instruction), its address on `outPc` and its destination on `outReg`. `lkPc` always equals `inPc` in the same cycle.
- R3: When `lkHit` and `lkReady` are both high and a slot is free, the instruction is replaced by the strand. One cycle later the output has `outKind`=1, `outPc`=the instruction's address, `outReg`=`lkDst`, and `outSlot`=the lowest free slot. When `lkHit` is high but `lkReady` is low, the instruction passes as in R2.
- R4: An instruction whose address equals the next expected member address of an active slot (first `lkPc2`, then `lkPc3`) produces no output and keeps `inReady` high. This matching takes priority over every repair check. Removing the `lkPc3` member frees the slot.
- R5: Inserting a strand marks `lkTmp1` and `lkTmp2` dirty, owned by that slot. An ordinary instruction that reads a dirty register drives `inReady` low. One cycle later the output has `outKind`=2, `outReg`=that register and `outSlot`=its owner, and the register is then clean. Source A is repaired before source B.
- R6: A passed instruction clears the dirty bit of its destination. Removing a strand's final member clears every dirty bit owned by that slot.
- R7: An ordinary instruction with clean sources that reads the final register of an active slot drives `inReady` low. One cycle later the output has `outKind`=3, `outReg`=that register, `outSlot`=the slot and `outImm`=the `lkOldVal` captured at insertion. The slot is released, so its remaining members then pass as ordinary instructions.
- R8: A cycle with `flush` high drops the input and emits nothing. It clears all slots and the dirty table. On the next cycle only, `killMask` has bit i set for each slot i that was active.
- R9: The engine takes at most one action per cycle and inserts at most one strand per cycle. When every slot is active, a lookup hit passes as a plain instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Branch flush |
| inValid | input | 1 | Input instruction valid |
| inPc | input | PCW | Instruction address |
| inDst | input | log2(NREG) | Destination register |
| inSrcA | input | log2(NREG) | First source register |
| inSrcB | input | log2(NREG) | Second source register |
| inReady | output | 1 | Low when the input is held for a repair |
| lkPc | output | PCW | Strand lookup address |
| lkHit | input | 1 | A cached strand starts at `lkPc` |
| lkReady | input | 1 | The strand's live inputs are ready |
| lkPc2 | input | PCW | Address of the second member |
| lkPc3 | input | PCW | Address of the final member |
| lkTmp1 | input | log2(NREG) | First skipped intermediate register |
| lkTmp2 | input | log2(NREG) | Second skipped intermediate register |
| lkDst | input | log2(NREG) | Final register of the strand |
| lkOldVal | input | DW | Value of `lkDst` before the strand |
| outValid | output | 1 | Output slot holds an operation |
| outKind | output | 2 | 0 instruction, 1 strand, 2 recovery, 3 load-immediate |
| outPc | output | PCW | Address of the triggering instruction |
| outReg | output | log2(NREG) | Register written by the operation |
| outSlot | output | log2(NSLOT) | Strand slot concerned |
| outImm | output | DW | Load-immediate value, else 0 |
| killMask | output | NSLOT | One-cycle kill per in-flight strand slot |

## Verification
The bench sweeps every register as a skipped intermediate with both sources dirty. A design that repaired sources in the wrong order, or credited the repair to the wrong slot, would emit the wrong register first. The bench runs a member instruction that reads a dirty register. A design that checked repairs before member matching would stall there and emit a needless recovery. It fills both slots and then presents a third hit, which a design with broken slot allocation would insert anyway or place in an occupied slot. It checks that a member arriving after a load-immediate, or after a flush, passes as a plain instruction. A design that kept stale tracking would swallow it, and a design with a latched or missing kill pulse shows up in the cycles right after the flush.

// File: rtl/sd_pkg.sv
package sd_pkg;

  typedef enum logic [1:0] {
    KIND_INSTR   = 2'd0,
    KIND_STRAND  = 2'd1,
    KIND_RECOVER = 2'd2,
    KIND_LOADIMM = 2'd3
  } outKind_e;

  // one decision per cycle from control to datapath
  typedef struct packed {
    logic doFlush;
    logic doSuppress;
    logic doFinal;
    logic doRecoverA;
    logic doRecoverB;
    logic doLoadImm;
    logic doInsert;
    logic doPass;
  } sdStrobe_t;

endpackage

// File: rtl/sd_ctrl.sv
module sd_ctrl
  import sd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       inValid,
  input  logic       lkHit,
  input  logic       lkReady,
  input  logic       anyMember,
  input  logic       memberFinal,
  input  logic       dirtyA,
  input  logic       dirtyB,
  input  logic       anyAnti,
  input  logic       anyFree,
  output sdStrobe_t  ctl,
  output logic       inReady
);

  // fixed priority: flush, member removal, repairs, insertion, plain issue
  always_comb begin
    ctl     = '0;
    inReady = 1'b1;
    if (flush) begin
      ctl.doFlush = 1'b1;
    end else if (inValid) begin
      if (anyMember) begin
        ctl.doSuppress = 1'b1;
        ctl.doFinal    = memberFinal;
      end else if (dirtyA) begin
        ctl.doRecoverA = 1'b1;
        inReady        = 1'b0;
      end else if (dirtyB) begin
        ctl.doRecoverB = 1'b1;
        inReady        = 1'b0;
      end else if (anyAnti) begin
        ctl.doLoadImm = 1'b1;
        inReady       = 1'b0;
      end else if (lkHit && lkReady && anyFree) begin
        ctl.doInsert = 1'b1;
      end else begin
        ctl.doPass = 1'b1;
      end
    end
  end

  // R9: one action per cycle
  assert_one_action_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doFlush, ctl.doSuppress, ctl.doRecoverA, ctl.doRecoverB,
              ctl.doLoadImm, ctl.doInsert, ctl.doPass}));

  // R5/R7: a stall only ever holds a live, unflushed instruction
  assert_stall_live_R5: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (inValid && !flush && !anyMember));

endmodule

// File: rtl/sd_data.sv
module sd_data
  import sd_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NSLOT = 2,
  parameter int PCW   = 16,
  parameter int DW    = 16,
  localparam int RW   = $clog2(NREG),
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sdStrobe_t        ctl,
  input  logic [PCW-1:0]   inPc,
  input  logic [RW-1:0]    inDst,
  input  logic [RW-1:0]    inSrcA,
  input  logic [RW-1:0]    inSrcB,
  input  logic             lkHit,
  input  logic             lkReady,
  input  logic [PCW-1:0]   lkPc2,
  input  logic [PCW-1:0]   lkPc3,
  input  logic [RW-1:0]    lkTmp1,
  input  logic [RW-1:0]    lkTmp2,
  input  logic [RW-1:0]    lkDst,
  input  logic [DW-1:0]    lkOldVal,
  output logic             anyMember,
  output logic             memberFinal,
  output logic             dirtyA,
  output logic             dirtyB,
  output logic             anyAnti,
  output logic             anyFree,
  output logic             outValid,
  output logic [1:0]       outKind,
  output logic [PCW-1:0]   outPc,
  output logic [RW-1:0]    outReg,
  output logic [SW-1:0]    outSlot,
  output logic [DW-1:0]    outImm,
  output logic [NSLOT-1:0] killMask
);

  // strand slots
  logic [NSLOT-1:0] slotAct;
  logic [NSLOT-1:0] slotStep;
  logic [PCW-1:0]   slotPc2 [NSLOT];
  logic [PCW-1:0]   slotPc3 [NSLOT];
  logic [RW-1:0]    slotDst [NSLOT];
  logic [DW-1:0]    slotOld [NSLOT];

  // dirty table
  logic [NREG-1:0]  dirty;
  logic [SW-1:0]    dirtyOwn [NREG];

  logic [NSLOT-1:0] memberVec, antiVec;
  logic [SW-1:0]    memberSlot, antiSlot, freeSlot;

  for (genvar i = 0; i < NSLOT; i++) begin : gSlot
    assign memberVec[i] = slotAct[i] &&
                          (inPc == (slotStep[i] ? slotPc3[i] : slotPc2[i]));
    assign antiVec[i]   = slotAct[i] &&
                          (slotDst[i] == inSrcA || slotDst[i] == inSrcB);
  end

  // lowest index wins for every selection
  always_comb begin
    memberSlot = '0;
    antiSlot   = '0;
    freeSlot   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (memberVec[i]) memberSlot = SW'(i);
      if (antiVec[i])   antiSlot   = SW'(i);
      if (!slotAct[i])  freeSlot   = SW'(i);
    end
  end

  assign anyMember   = |memberVec;
  assign memberFinal = slotStep[memberSlot];
  assign anyAnti     = |antiVec;
  assign anyFree     = ~&slotAct;
  assign dirtyA      = dirty[inSrcA];
  assign dirtyB      = dirty[inSrcB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotAct  <= '0;
      slotStep <= '0;
      dirty    <= '0;
      outValid <= 1'b0;
      outKind  <= KIND_INSTR;
      outPc    <= '0;
      outReg   <= '0;
      outSlot  <= '0;
      outImm   <= '0;
      killMask <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        slotPc2[i] <= '0;
        slotPc3[i] <= '0;
        slotDst[i] <= '0;
        slotOld[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) dirtyOwn[r] <= '0;
    end else begin
      outValid <= 1'b0;
      killMask <= '0;
      outImm   <= '0;
      outPc    <= inPc;
      outSlot  <= '0;
      if (ctl.doFlush) begin
        killMask <= slotAct;
        slotAct  <= '0;
        dirty    <= '0;
      end
      if (ctl.doSuppress) begin
        if (ctl.doFinal) begin
          slotAct[memberSlot] <= 1'b0;
          for (int r = 0; r < NREG; r++)
            if (dirtyOwn[r] == memberSlot) dirty[r] <= 1'b0;
        end else begin
          slotStep[memberSlot] <= 1'b1;
        end
      end
      if (ctl.doRecoverA || ctl.doRecoverB) begin
        outValid <= 1'b1;
        outKind  <= KIND_RECOVER;
        outReg   <= ctl.doRecoverA ? inSrcA : inSrcB;
        outSlot  <= ctl.doRecoverA ? dirtyOwn[inSrcA] : dirtyOwn[inSrcB];
        dirty[ctl.doRecoverA ? inSrcA : inSrcB] <= 1'b0;
      end
      if (ctl.doLoadImm) begin
        outValid          <= 1'b1;
        outKind           <= KIND_LOADIMM;
        outReg            <= slotDst[antiSlot];
        outSlot           <= antiSlot;
        outImm            <= slotOld[antiSlot];
        slotAct[antiSlot] <= 1'b0;
      end
      if (ctl.doInsert) begin
        outValid          <= 1'b1;
        outKind           <= KIND_STRAND;
        outReg            <= lkDst;
        outSlot           <= freeSlot;
        slotAct[freeSlot] <= 1'b1;
        slotStep[freeSlot] <= 1'b0;
        slotPc2[freeSlot] <= lkPc2;
        slotPc3[freeSlot] <= lkPc3;
        slotDst[freeSlot] <= lkDst;
        slotOld[freeSlot] <= lkOldVal;
        dirty[lkDst]      <= 1'b0;
        dirty[lkTmp1]     <= 1'b1;
        dirty[lkTmp2]     <= 1'b1;
        dirtyOwn[lkTmp1]  <= freeSlot;
        dirtyOwn[lkTmp2]  <= freeSlot;
      end
      if (ctl.doPass) begin
        outValid     <= 1'b1;
        outKind      <= KIND_INSTR;
        outReg       <= inDst;
        dirty[inDst] <= 1'b0;
      end
    end
  end

  // R8: kill pulses only right after a flush, and the flush leaves nothing behind
  assert_kill_after_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    (killMask != '0) |-> $past(ctl.doFlush));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doFlush |=> (slotAct == '0 && dirty == '0));

  // R3: a strand leaves only after a ready hit
  assert_strand_needs_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_STRAND) |-> $past(lkHit && lkReady));

  // R4: a removed member emits nothing
  assert_member_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doSuppress |=> !outValid);

  // R7: a load-immediate releases its slot
  assert_loadimm_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doLoadImm |=> ($countones(slotAct) < $countones($past(slotAct))));

endmodule

// File: rtl/strand_dispatch.sv
module strand_dispatch
  import sd_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NSLOT = 2,
  parameter int PCW   = 16,
  parameter int DW    = 16,
  localparam int RW   = $clog2(NREG),
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  input  logic [PCW-1:0]   inPc,
  input  logic [RW-1:0]    inDst,
  input  logic [RW-1:0]    inSrcA,
  input  logic [RW-1:0]    inSrcB,
  output logic             inReady,
  output logic [PCW-1:0]   lkPc,
  input  logic             lkHit,
  input  logic             lkReady,
  input  logic [PCW-1:0]   lkPc2,
  input  logic [PCW-1:0]   lkPc3,
  input  logic [RW-1:0]    lkTmp1,
  input  logic [RW-1:0]    lkTmp2,
  input  logic [RW-1:0]    lkDst,
  input  logic [DW-1:0]    lkOldVal,
  output logic             outValid,
  output logic [1:0]       outKind,
  output logic [PCW-1:0]   outPc,
  output logic [RW-1:0]    outReg,
  output logic [SW-1:0]    outSlot,
  output logic [DW-1:0]    outImm,
  output logic [NSLOT-1:0] killMask
);

  sdStrobe_t ctl;
  logic anyMember, memberFinal, dirtyA, dirtyB, anyAnti, anyFree;

  assign lkPc = inPc;

  sd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid),
    .lkHit(lkHit), .lkReady(lkReady), .anyMember(anyMember),
    .memberFinal(memberFinal), .dirtyA(dirtyA), .dirtyB(dirtyB),
    .anyAnti(anyAnti), .anyFree(anyFree), .ctl(ctl), .inReady(inReady)
  );

  sd_data #(.NREG(NREG), .NSLOT(NSLOT), .PCW(PCW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inPc(inPc), .inDst(inDst),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .lkHit(lkHit), .lkReady(lkReady),
    .lkPc2(lkPc2), .lkPc3(lkPc3), .lkTmp1(lkTmp1), .lkTmp2(lkTmp2),
    .lkDst(lkDst), .lkOldVal(lkOldVal), .anyMember(anyMember),
    .memberFinal(memberFinal), .dirtyA(dirtyA), .dirtyB(dirtyB),
    .anyAnti(anyAnti), .anyFree(anyFree), .outValid(outValid),
    .outKind(outKind), .outPc(outPc), .outReg(outReg), .outSlot(outSlot),
    .outImm(outImm), .killMask(killMask)
  );

endmodule

// File: tb/sim_strand_dispatch.sv
module sim_strand_dispatch;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, inValid = 1'b0;
  logic [15:0] inPc = '0;
  logic [2:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic inReady;
  logic [15:0] lkPc;
  logic lkHit = 1'b0, lkReady = 1'b0;
  logic [15:0] lkPc2 = '0, lkPc3 = '0;
  logic [2:0] lkTmp1 = '0, lkTmp2 = '0, lkDst = '0;
  logic [15:0] lkOldVal = '0;
  logic outValid;
  logic [1:0] outKind;
  logic [15:0] outPc;
  logic [2:0] outReg;
  logic [0:0] outSlot;
  logic [15:0] outImm;
  logic [1:0] killMask;

  int nTests = 0, nFail = 0;
  logic readyS;
  logic [15:0] lkPcS;

  always #5 clk = ~clk;

  strand_dispatch u0 (.*);

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic v, input logic [1:0] k,
                          input logic [15:0] pc, input logic [2:0] rg,
                          input logic sl, input logic [15:0] imm);
    nTests++;
    if (outValid !== v ||
        (v && (outKind !== k || outPc !== pc || outReg !== rg ||
               outSlot !== sl || outImm !== imm))) begin
      nFail++;
      $display("FAIL %s out: actual v%0d k%0d pc%0h r%0d s%0d i%0h expected v%0d k%0d pc%0h r%0d s%0d i%0h",
               req, outValid, outKind, outPc, outReg, outSlot, outImm, v, k, pc, rg, sl, imm);
    end
  endtask

  task automatic setLk(input logic [15:0] p2, p3, input logic [2:0] t1, t2, d,
                       input logic [15:0] old);
    lkHit = 1'b1; lkReady = 1'b1; lkPc2 = p2; lkPc3 = p3;
    lkTmp1 = t1; lkTmp2 = t2; lkDst = d; lkOldVal = old;
  endtask

  task automatic clearLk();
    lkHit = 1'b0; lkReady = 1'b0;
  endtask

  // apply one cycle of input, sample ready/lookup, then step past the edge
  task automatic go(input logic v, input logic [15:0] pc, input logic [2:0] d, a, b);
    inValid = v; inPc = pc; inDst = d; inSrcA = a; inSrcB = b;
    #1;
    readyS = inReady;
    lkPcS = lkPc;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1
    checkVal("R1", "outValid", outValid, 0);
    checkVal("R1", "killMask", killMask, 0);
    checkVal("R1", "inReady", inReady, 1);

    // R2 plain pass
    go(1, 16'h10, 5, 1, 2);
    checkVal("R2", "ready", readyS, 1);
    checkVal("R2", "lkPc", lkPcS, 16'h10);
    checkOut("R2", 1, 0, 16'h10, 5, 0, 0);

    // R3 hit without ready passes
    setLk(16'h14, 16'h16, 1, 2, 3, 16'h0);
    lkReady = 1'b0;
    go(1, 16'h12, 4, 1, 2);
    checkOut("R3", 1, 0, 16'h12, 4, 0, 0);
    clearLk();

    // R3 insertion
    setLk(16'h24, 16'h28, 1, 2, 3, 16'hABCD);
    go(1, 16'h20, 1, 6, 7);
    checkVal("R3", "lkPc", lkPcS, 16'h20);
    checkOut("R3", 1, 1, 16'h20, 3, 0, 0);
    clearLk();

    // R4 member reading a dirty register is still removed
    go(1, 16'h24, 2, 1, 5);
    checkVal("R4", "ready", readyS, 1);
    checkOut("R4", 0, 0, 0, 0, 0, 0);

    // R5 dirty read repaired, then passes
    go(1, 16'h30, 7, 2, 4);
    checkVal("R5", "ready", readyS, 0);
    checkOut("R5", 1, 2, 16'h30, 2, 0, 0);
    go(1, 16'h30, 7, 2, 4);
    checkVal("R5", "ready after", readyS, 1);
    checkOut("R5", 1, 0, 16'h30, 7, 0, 0);

    // R4/R6 final member removed, clears r1
    go(1, 16'h28, 3, 2, 6);
    checkOut("R4", 0, 0, 0, 0, 0, 0);
    go(1, 16'h32, 5, 1, 1);
    checkVal("R6", "ready", readyS, 1);
    checkOut("R6", 1, 0, 16'h32, 5, 0, 0);

    // R9 fill both slots, third hit passes
    setLk(16'h44, 16'h48, 4, 5, 6, 16'h1111);
    go(1, 16'h40, 0, 0, 0);
    checkOut("R9", 1, 1, 16'h40, 6, 0, 0);
    setLk(16'h54, 16'h58, 7, 7, 2, 16'h2222);
    go(1, 16'h50, 0, 0, 0);
    checkOut("R9", 1, 1, 16'h50, 2, 1, 0);
    setLk(16'h64, 16'h68, 1, 1, 1, 16'h0);
    go(1, 16'h60, 3, 0, 0);
    checkOut("R9", 1, 0, 16'h60, 3, 0, 0);
    clearLk();

    // R6 pass-through write clears dirty r5
    go(1, 16'h70, 5, 0, 0);
    checkOut("R6", 1, 0, 16'h70, 5, 0, 0);
    go(1, 16'h72, 1, 5, 0);
    checkVal("R6", "ready", readyS, 1);
    checkOut("R6", 1, 0, 16'h72, 1, 0, 0);

    // R7 anti-dependence on slot0 final register r6
    go(1, 16'h74, 0, 0, 6);
    checkVal("R7", "ready", readyS, 0);
    checkOut("R7", 1, 3, 16'h74, 6, 0, 16'h1111);
    go(1, 16'h74, 0, 0, 6);
    checkOut("R7", 1, 0, 16'h74, 0, 0, 0);
    go(1, 16'h44, 3, 0, 0);
    checkOut("R7", 1, 0, 16'h44, 3, 0, 0);

    // R8 flush with slot1 in flight
    flush = 1'b1;
    go(1, 16'h90, 0, 0, 0);
    flush = 1'b0;
    checkOut("R8", 0, 0, 0, 0, 0, 0);
    checkVal("R8", "killMask", killMask, 2'b10);
    go(0, 16'h0, 0, 0, 0);
    checkVal("R8", "kill pulse", killMask, 0);
    go(1, 16'h92, 0, 7, 4);
    checkOut("R8", 1, 0, 16'h92, 0, 0, 0);
    go(1, 16'h94, 0, 2, 2);
    checkOut("R8", 1, 0, 16'h94, 0, 0, 0);
    go(1, 16'h54, 1, 0, 0);
    checkOut("R8", 1, 0, 16'h54, 1, 0, 0);

    // sweep every register as a skipped intermediate
    for (int r = 0; r < 8; r++) begin
      logic [15:0] base;
      logic [2:0] rr, ra, rd;
      base = 16'h100 + 16'(r * 16);
      rr = 3'(r);
      ra = 3'((r + 4) % 8);
      rd = 3'((r + 1) % 8);
      setLk(base + 16'h4, base + 16'h6, rr, ra, rd, 16'(r * 16 + 3));
      go(1, base, 0, 0, 0);
      checkOut("R3", 1, 1, base, rd, 0, 0);
      clearLk();
      go(1, base + 16'h8, 0, ra, rr);
      checkOut("R5", 1, 2, base + 16'h8, ra, 0, 0);
      go(1, base + 16'h8, 0, ra, rr);
      checkOut("R5", 1, 2, base + 16'h8, rr, 0, 0);
      go(1, base + 16'h8, 0, ra, rr);
      checkOut("R5", 1, 0, base + 16'h8, 0, 0, 0);
      flush = 1'b1;
      go(0, 16'h0, 0, 0, 0);
      flush = 1'b0;
      checkVal("R8", "sweep killMask", killMask, 2'b01);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule